// File: doc/BRIEF.md
# Register-Mapped Function Call Sequencer

This block is a bus master that runs one complete function call against an accelerator whose interface is a set of memory-mapped registers. A local client presents an operation code, four 32-bit operands and a one-cycle start request. The sequencer then uses single-beat AXI4-Lite accesses to load the operation code and operands into the accelerator. It fires the accelerator through its control word and polls that word for completion. Once the call ends it parks the control word at zero and, on success, fetches the four result words.

The client sees a busy flag for the whole call and a one-cycle completion strobe. The strobe carries the four returned words and a two-bit outcome code. A call ends early in two cases: completion never shows within a bounded number of polls, or the slave answers any access with a non-OKAY response. At most one bus access is in flight at any time. No bursts are issued.

Top module: `rpcm_call_master`

## Requirements
- R1: After reset, `busy_o`, `res_valid_o`, `m_awvalid`, `m_wvalid`, `m_bready`, `m_arvalid` and `m_rready` are all 0.
- R2: A `go_i` pulse while idle starts a call: `busy_o` is 1 from the next cycle up to the cycle before the completion strobe, and is 0 in the strobe cycle.
- R3: A `go_i` pulse while `busy_o` is 1 has no effect: it triggers no extra bus access, and neither the latched operation code nor the latched operands change.
- R4: A call first writes the operation code to offset 0x04, then operand k to offset 0x08+4k for k = 0,1,2,3 in ascending order, and then writes 0x00000003 to the control word at offset 0x00 (bit 0 fire, bit 1 armed). Every write has all byte strobes set, and each offset is added to parameter `BASE_ADDR`.
- R5: After firing, the sequencer reads offset 0x00 repeatedly until a read returns bit 2 (completion) set. Completion on any poll up to and including poll number `POLL_LIMIT` (default 100) counts as success.
- R6: On success the sequencer writes 0 to offset 0x00, then reads offsets 0x18, 0x1C, 0x20 and 0x24 in that order. It then strobes with outcome 0, and result k sits in `results_o[32k+31:32k]`.
- R7: If `POLL_LIMIT` polls all return bit 2 clear, the sequencer writes 0 to offset 0x00 and reads no result. It then strobes with outcome 1 and all result bits 0.
- R8: A BRESP or RRESP other than 0 (OKAY) on any access ends the call at once with no further access. The sequencer then strobes with outcome 2 and all result bits 0.
- R9: For a write, AWVALID and WVALID rise together. Each is held with stable address and data until its own READY. BREADY is raised only after both handshakes, and no other access starts before the BVALID/BREADY handshake.
- R10: For a read, ARVALID is held with a stable address until ARREADY, then RREADY is raised and data is taken on RVALID with RREADY. Reads never overlap a write.
- R11: `res_valid_o` is high for exactly one cycle per accepted call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | One-cycle request to start a call |
| method_i | input | 32 | Operation code, latched at start |
| args_i | input | 128 | Four operands, operand k at bits [32k+31:32k] |
| busy_o | output | 1 | Call in progress |
| res_valid_o | output | 1 | One-cycle completion strobe |
| res_status_o | output | 2 | Outcome: 0 success, 1 poll timeout, 2 bus error |
| results_o | output | 128 | Four returned words, word k at bits [32k+31:32k] |
| m_awaddr | output | 32 | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench drives calls against a behavioural slave with an accelerator behind it. Address and data ready signals follow different periodic patterns, so the two write handshakes land in either order. Calls with the add and echo codes, including wrap-around sums, show whether result words are fetched from the right offsets in the right order. Completion on the first poll, on a middle poll and on exactly the last allowed poll separates the success and timeout boundary, and a slave that never completes exercises the timeout path. Injected error responses on an operand write and on a poll read, plus a second start pulse in mid-call, confirm that the access log stops at the failing access and that the second pulse causes nothing.

// File: rtl/rpcm_pkg.sv
package rpcm_pkg;

    // control word fields
    localparam logic [31:0] CTRL_FIRE_WORD  = 32'h0000_0003;  // fire + armed
    localparam logic [31:0] CTRL_PARK_WORD  = 32'h0000_0000;
    localparam int unsigned CTRL_DONE_BIT   = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_KICK,
        PH_POLL,
        PH_CLEAR,
        PH_FETCH
    } phase_e;

    typedef enum logic [1:0] {
        CALL_OK      = 2'd0,
        CALL_TIMEOUT = 2'd1,
        CALL_BUSERR  = 2'd2
    } call_status_e;

    // one scripted bus access
    typedef struct packed {
        logic        wr;
        logic [31:0] off;
        logic [31:0] wdata;
    } access_t;

    function automatic logic [31:0] off_ctrl();
        return 32'h0000_0000;
    endfunction

    function automatic logic [31:0] off_method();
        return 32'h0000_0004;
    endfunction

    function automatic logic [31:0] off_arg(input int unsigned k);
        return 32'(8 + 4 * k);
    endfunction

    // results follow the operand block
    function automatic logic [31:0] off_res(input int unsigned n_args, input int unsigned k);
        return 32'(8 + 4 * n_args + 4 * k);
    endfunction

endpackage

// File: rtl/rpcm_axil_port.sv
module rpcm_axil_port
    import rpcm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic                req_wr_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    output logic                ack_o,
    output logic                ack_err_o,
    output logic [DATA_W-1:0]   ack_rdata_o,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rvalid,
    output logic                m_rready
);

    logic aw_v_q, w_v_q, b_r_q, wr_act_q, ar_v_q, r_r_q;
    logic aw_clear, w_clear;

    assign aw_clear = !aw_v_q || m_awready;
    assign w_clear  = !w_v_q  || m_wready;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_v_q      <= 1'b0;
            w_v_q       <= 1'b0;
            b_r_q       <= 1'b0;
            wr_act_q    <= 1'b0;
            ar_v_q      <= 1'b0;
            r_r_q       <= 1'b0;
            ack_o       <= 1'b0;
            ack_err_o   <= 1'b0;
            ack_rdata_o <= '0;
            m_awaddr    <= '0;
            m_wdata     <= '0;
            m_araddr    <= '0;
        end else begin
            ack_o <= 1'b0;
            if (req_i) begin
                if (req_wr_i) begin
                    aw_v_q   <= 1'b1;
                    w_v_q    <= 1'b1;
                    wr_act_q <= 1'b1;
                    m_awaddr <= req_addr_i;
                    m_wdata  <= req_wdata_i;
                end else begin
                    ar_v_q   <= 1'b1;
                    m_araddr <= req_addr_i;
                end
            end
            if (aw_v_q && m_awready) aw_v_q <= 1'b0;
            if (w_v_q && m_wready)   w_v_q  <= 1'b0;
            if (wr_act_q && !b_r_q && aw_clear && w_clear) b_r_q <= 1'b1;
            if (b_r_q && m_bvalid) begin
                b_r_q     <= 1'b0;
                wr_act_q  <= 1'b0;
                ack_o     <= 1'b1;
                ack_err_o <= (m_bresp != 2'b00);
            end
            if (ar_v_q && m_arready) begin
                ar_v_q <= 1'b0;
                r_r_q  <= 1'b1;
            end
            if (r_r_q && m_rvalid) begin
                r_r_q       <= 1'b0;
                ack_o       <= 1'b1;
                ack_err_o   <= (m_rresp != 2'b00);
                ack_rdata_o <= m_rdata;
            end
        end
    end

    assign m_awvalid = aw_v_q;
    assign m_wvalid  = w_v_q;
    assign m_bready  = b_r_q;
    assign m_arvalid = ar_v_q;
    assign m_rready  = r_r_q;
    assign m_wstrb   = '1;

    // R9: address and data stay up until accepted
    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
    assert_w_hold_R9: assert property (@(posedge clk) disable iff (rst)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));
    assert_b_after_R9: assert property (@(posedge clk) disable iff (rst)
        m_bready |-> !m_awvalid && !m_wvalid);
    // R10: read address held, reads never overlap writes
    assert_ar_hold_R10: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        (m_arvalid || m_rready) |-> !(m_awvalid || m_wvalid || m_bready));

endmodule

// File: rtl/rpcm_script.sv
module rpcm_script
    import rpcm_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned N_WORDS    = 4,
    parameter int unsigned POLL_LIMIT = 100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go_i,
    input  logic [DATA_W-1:0]         method_i,
    input  logic [N_WORDS*DATA_W-1:0] args_i,
    output logic                      busy_o,
    output logic                      res_valid_o,
    output logic [1:0]                res_status_o,
    output logic [N_WORDS*DATA_W-1:0] results_o,
    output logic                      req_o,
    output access_t                   req_acc_o,
    input  logic                      ack_i,
    input  logic                      ack_err_i,
    input  logic [DATA_W-1:0]         ack_rdata_i
);

    localparam int unsigned IDX_W  = $clog2(N_WORDS + 1);
    localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST_LOAD  = IDX_W'(N_WORDS);
    localparam logic [IDX_W-1:0]  IDX_LAST_FETCH = IDX_W'(N_WORDS - 1);
    localparam logic [POLL_W-1:0] POLL_LAST      = POLL_W'(POLL_LIMIT - 1);

    phase_e              phase_q;
    call_status_e        status_q;
    logic [IDX_W-1:0]    idx_q;
    logic [POLL_W-1:0]   poll_q;
    logic                pend_q, timed_out_q, valid_q;
    logic [DATA_W-1:0]   meth_q;
    logic [DATA_W-1:0]   arg_q [N_WORDS];
    logic [DATA_W-1:0]   res_q [N_WORDS];

    assign busy_o = (phase_q != PH_IDLE);
    assign req_o  = busy_o && !pend_q;

    // access selected by the current script step
    always_comb begin
        req_acc_o = '0;
        unique case (phase_q)
            PH_LOAD: begin
                req_acc_o.wr = 1'b1;
                if (idx_q == '0) begin
                    req_acc_o.off   = off_method();
                    req_acc_o.wdata = 32'(meth_q);
                end
                for (int k = 0; k < N_WORDS; k++) begin
                    if (idx_q == IDX_W'(k + 1)) begin
                        req_acc_o.off   = off_arg(k);
                        req_acc_o.wdata = 32'(arg_q[k]);
                    end
                end
            end
            PH_KICK: begin
                req_acc_o.wr    = 1'b1;
                req_acc_o.off   = off_ctrl();
                req_acc_o.wdata = CTRL_FIRE_WORD;
            end
            PH_POLL: req_acc_o.off = off_ctrl();
            PH_CLEAR: begin
                req_acc_o.wr    = 1'b1;
                req_acc_o.off   = off_ctrl();
                req_acc_o.wdata = CTRL_PARK_WORD;
            end
            PH_FETCH: req_acc_o.off = off_res(N_WORDS, 0) + 32'({idx_q, 2'b00});
            default: req_acc_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            status_q    <= CALL_OK;
            idx_q       <= '0;
            poll_q      <= '0;
            pend_q      <= 1'b0;
            timed_out_q <= 1'b0;
            valid_q     <= 1'b0;
            meth_q      <= '0;
            for (int k = 0; k < N_WORDS; k++) begin
                arg_q[k] <= '0;
                res_q[k] <= '0;
            end
        end else begin
            valid_q <= 1'b0;
            if (req_o) pend_q <= 1'b1;
            if (phase_q == PH_IDLE) begin
                if (go_i) begin
                    meth_q      <= method_i;
                    idx_q       <= '0;
                    poll_q      <= '0;
                    timed_out_q <= 1'b0;
                    phase_q     <= PH_LOAD;
                    for (int k = 0; k < N_WORDS; k++) begin
                        arg_q[k] <= args_i[k*DATA_W +: DATA_W];
                        res_q[k] <= '0;
                    end
                end
            end else if (ack_i) begin
                pend_q <= 1'b0;
                if (ack_err_i) begin
                    phase_q  <= PH_IDLE;
                    valid_q  <= 1'b1;
                    status_q <= CALL_BUSERR;
                    for (int k = 0; k < N_WORDS; k++) res_q[k] <= '0;
                end else begin
                    unique case (phase_q)
                        PH_LOAD: begin
                            if (idx_q == IDX_LAST_LOAD) begin
                                idx_q   <= '0;
                                phase_q <= PH_KICK;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                        PH_KICK: phase_q <= PH_POLL;
                        PH_POLL: begin
                            if (ack_rdata_i[CTRL_DONE_BIT]) begin
                                phase_q <= PH_CLEAR;
                            end else if (poll_q == POLL_LAST) begin
                                timed_out_q <= 1'b1;
                                phase_q     <= PH_CLEAR;
                            end else begin
                                poll_q <= poll_q + 1'b1;
                            end
                        end
                        PH_CLEAR: begin
                            if (timed_out_q) begin
                                phase_q  <= PH_IDLE;
                                valid_q  <= 1'b1;
                                status_q <= CALL_TIMEOUT;
                            end else begin
                                idx_q   <= '0;
                                phase_q <= PH_FETCH;
                            end
                        end
                        PH_FETCH: begin
                            res_q[idx_q] <= ack_rdata_i;
                            if (idx_q == IDX_LAST_FETCH) begin
                                phase_q  <= PH_IDLE;
                                valid_q  <= 1'b1;
                                status_q <= CALL_OK;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign res_valid_o  = valid_q;
    assign res_status_o = status_q;
    for (genvar g = 0; g < N_WORDS; g++) begin : g_res
        assign results_o[g*DATA_W +: DATA_W] = res_q[g];
    end

    // R2: a call begins only from a start request
    assert_start_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(go_i));
    // R3: latched call inputs frozen while busy
    assert_ignore_go_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o && go_i |=> $stable(meth_q) && $stable(arg_q[0]));
    // R7: poll counter stays within its window
    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (rst)
        poll_q < POLL_W'(POLL_LIMIT));
    // R7/R8: failed calls return no data
    assert_fail_zero_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid_o && (res_status_o != 2'd0) |-> results_o == '0);
    // R11: strobe is a single pulse
    assert_strobe_once_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

endmodule

// File: rtl/rpcm_call_master.sv
module rpcm_call_master
    import rpcm_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned N_WORDS    = 4,
    parameter int unsigned POLL_LIMIT = 100,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go_i,
    input  logic [DATA_W-1:0]         method_i,
    input  logic [N_WORDS*DATA_W-1:0] args_i,
    output logic                      busy_o,
    output logic                      res_valid_o,
    output logic [1:0]                res_status_o,
    output logic [N_WORDS*DATA_W-1:0] results_o,
    output logic [ADDR_W-1:0]         m_awaddr,
    output logic                      m_awvalid,
    input  logic                      m_awready,
    output logic [DATA_W-1:0]         m_wdata,
    output logic [DATA_W/8-1:0]       m_wstrb,
    output logic                      m_wvalid,
    input  logic                      m_wready,
    input  logic [1:0]                m_bresp,
    input  logic                      m_bvalid,
    output logic                      m_bready,
    output logic [ADDR_W-1:0]         m_araddr,
    output logic                      m_arvalid,
    input  logic                      m_arready,
    input  logic [DATA_W-1:0]         m_rdata,
    input  logic [1:0]                m_rresp,
    input  logic                      m_rvalid,
    output logic                      m_rready
);

    logic              req;
    access_t           acc;
    logic              ack, ack_err;
    logic [DATA_W-1:0] ack_rdata;
    logic [ADDR_W-1:0] req_addr;

    assign req_addr = BASE_ADDR + ADDR_W'(acc.off);

    rpcm_script #(
        .DATA_W     (DATA_W),
        .N_WORDS    (N_WORDS),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_script (
        .clk          (clk),
        .rst          (rst),
        .go_i         (go_i),
        .method_i     (method_i),
        .args_i       (args_i),
        .busy_o       (busy_o),
        .res_valid_o  (res_valid_o),
        .res_status_o (res_status_o),
        .results_o    (results_o),
        .req_o        (req),
        .req_acc_o    (acc),
        .ack_i        (ack),
        .ack_err_i    (ack_err),
        .ack_rdata_i  (ack_rdata)
    );

    rpcm_axil_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .req_wr_i    (acc.wr),
        .req_addr_i  (req_addr),
        .req_wdata_i (DATA_W'(acc.wdata)),
        .ack_o       (ack),
        .ack_err_o   (ack_err),
        .ack_rdata_o (ack_rdata),
        .m_awaddr    (m_awaddr),
        .m_awvalid   (m_awvalid),
        .m_awready   (m_awready),
        .m_wdata     (m_wdata),
        .m_wstrb     (m_wstrb),
        .m_wvalid    (m_wvalid),
        .m_wready    (m_wready),
        .m_bresp     (m_bresp),
        .m_bvalid    (m_bvalid),
        .m_bready    (m_bready),
        .m_araddr    (m_araddr),
        .m_arvalid   (m_arvalid),
        .m_arready   (m_arready),
        .m_rdata     (m_rdata),
        .m_rresp     (m_rresp),
        .m_rvalid    (m_rvalid),
        .m_rready    (m_rready)
    );

    // R2: busy drops in the strobe cycle
    assert_idle_at_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> !busy_o);
    // R1/R9: no bus activity while idle
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(m_awvalid || m_wvalid || m_arvalid));

endmodule

// File: tb/rpcm_call_master_test.sv
`timescale 1ns/1ps
module rpcm_call_master_test;

    localparam logic [31:0] BASE  = 32'h0000_2000;
    localparam int          NEVER = 1_000_000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go  = 1'b0;
    logic [31:0]  method = '0;
    logic [127:0] args = '0;
    logic         busy, res_valid;
    logic [1:0]   res_status;
    logic [127:0] results;
    logic [31:0]  awaddr, wdata, araddr;
    logic         awvalid, wvalid, bready, arvalid, rready;
    logic [3:0]   wstrb;
    logic         awready = 0, wready = 0, bvalid = 0, arready = 0, rvalid = 0;
    logic [1:0]   bresp = 0, rresp = 0;
    logic [31:0]  rdata = 0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rpcm_call_master #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .rst(rst), .go_i(go), .method_i(method), .args_i(args),
        .busy_o(busy), .res_valid_o(res_valid), .res_status_o(res_status), .results_o(results),
        .m_awaddr(awaddr), .m_awvalid(awvalid), .m_awready(awready),
        .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
        .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(bready),
        .m_araddr(araddr), .m_arvalid(arvalid), .m_arready(arready),
        .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(rready)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- slave and accelerator model ----------------
    logic [31:0] regs [10];
    int   need_polls = 1;
    int   err_at = -1;
    int   acc_n = 0;
    int   polls_seen = 0;
    bit   pending = 0;
    int   tick = 0;
    bit   aw_got = 0, w_got = 0;
    logic [31:0] aw_lat, w_lat;
    bit          lg_wr  [$];
    logic [31:0] lg_off [$];
    logic [31:0] lg_dat [$];

    function automatic logic [127:0] compute(input logic [31:0] m, input logic [127:0] a);
        logic [31:0] x0, x1, x2, x3;
        x0 = a[31:0]; x1 = a[63:32]; x2 = a[95:64]; x3 = a[127:96];
        if (m == 32'd0) return a;
        if (m == 32'd1) return {x1 + x3, x0 + x2, x2 + x3, x0 + x1};
        return '0;
    endfunction

    always @(posedge clk) begin
        tick++;
        if (rst) begin
            awready <= 0; wready <= 0; bvalid <= 0; arready <= 0; rvalid <= 0;
            aw_got = 0; w_got = 0; pending = 0;
            for (int i = 0; i < 10; i++) regs[i] = '0;
        end else begin
            awready <= awvalid && !awready && ((tick % 3) != 1);
            wready  <= wvalid && !wready && ((tick % 2) == 1);
            arready <= arvalid && !arready && ((tick % 4) != 0);
            if (awvalid && awready) begin aw_lat = awaddr - BASE; aw_got = 1; end
            if (wvalid && wready)   begin w_lat = wdata; w_got = 1; end
            if (bvalid && bready) bvalid <= 0;
            if (rvalid && rready) rvalid <= 0;
            if (aw_got && w_got && !bvalid) begin
                logic [127:0] r;
                aw_got = 0; w_got = 0;
                lg_wr.push_back(1); lg_off.push_back(aw_lat); lg_dat.push_back(w_lat);
                regs[aw_lat[5:2]] = w_lat;
                if (aw_lat == 0) begin
                    if (w_lat[0]) begin
                        pending = 1; polls_seen = 0;
                        r = compute(regs[1], {regs[5], regs[4], regs[3], regs[2]});
                        for (int i = 0; i < 4; i++) regs[6+i] = r[32*i +: 32];
                    end else pending = 0;
                end
                bresp  <= (acc_n == err_at) ? 2'b10 : 2'b00;
                bvalid <= 1;
                acc_n++;
            end
            if (arvalid && arready) begin
                logic [31:0] off, d;
                off = araddr - BASE;
                d = regs[off[5:2]];
                if (off == 0) begin
                    polls_seen++;
                    d[2] = pending && (polls_seen >= need_polls);
                end
                lg_wr.push_back(0); lg_off.push_back(off); lg_dat.push_back(d);
                rdata  <= d;
                rresp  <= (acc_n == err_at) ? 2'b10 : 2'b00;
                rvalid <= 1;
                acc_n++;
            end
        end
    end

    // ---------------- per-cycle handshake checks ----------------
    bit p_aw = 0, p_w = 0, p_ar = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_aw) chk("R9 AWVALID dropped before AWREADY", awvalid, 1);
            if (p_w)  chk("R9 WVALID dropped before WREADY", wvalid, 1);
            if (p_ar) chk("R10 ARVALID dropped before ARREADY", arvalid, 1);
            if (bready) chk("R9 BREADY with write channels open", awvalid | wvalid, 0);
            if (arvalid | rready) chk("R10 read overlaps write", awvalid | wvalid | bready, 0);
            if (awvalid) chk("R4 byte strobes", wstrb, 4'hF);
            p_aw = awvalid && !awready;
            p_w  = wvalid && !wready;
            p_ar = arvalid && !arready;
        end
    end

    // ---------------- one call with reference expectations ----------------
    task automatic run_call(input string name, input logic [31:0] m, input logic [127:0] a,
                            input int polls, input int err_idx);
        bit          ex_wr [$];
        logic [31:0] ex_off [$];
        logic [31:0] ex_dat [$];
        logic [127:0] exp_res;
        logic [1:0]   exp_st;
        int           guard;
        bit           timeout;
        timeout = (polls > 100);
        ex_wr.push_back(1); ex_off.push_back(32'h4); ex_dat.push_back(m);
        for (int k = 0; k < 4; k++) begin
            ex_wr.push_back(1); ex_off.push_back(32'(8 + 4*k)); ex_dat.push_back(a[32*k +: 32]);
        end
        ex_wr.push_back(1); ex_off.push_back(0); ex_dat.push_back(32'h3);
        for (int p = 0; p < (timeout ? 100 : polls); p++) begin
            ex_wr.push_back(0); ex_off.push_back(0); ex_dat.push_back(0);
        end
        ex_wr.push_back(1); ex_off.push_back(0); ex_dat.push_back(0);
        if (!timeout)
            for (int k = 0; k < 4; k++) begin
                ex_wr.push_back(0); ex_off.push_back(32'(24 + 4*k)); ex_dat.push_back(0);
            end
        exp_st  = timeout ? 2'd1 : 2'd0;
        exp_res = timeout ? '0 : compute(m, a);
        if (err_idx >= 0) begin
            while (ex_wr.size() > err_idx + 1) begin
                void'(ex_wr.pop_back()); void'(ex_off.pop_back()); void'(ex_dat.pop_back());
            end
            exp_st = 2'd2; exp_res = '0;
        end

        @(negedge clk);
        need_polls = polls; err_at = err_idx; acc_n = 0;
        lg_wr.delete(); lg_off.delete(); lg_dat.delete();
        method = m; args = a; go = 1;
        @(negedge clk);
        go = 0;
        chk({"R2 busy after start ", name}, busy, 1);
        guard = 0;
        while (!res_valid && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (!res_valid && busy !== 1) chk({"R2 busy during call ", name}, busy, 1);
        end
        chk({"R2 busy low at strobe ", name}, busy, 0);
        chk({"R6 R7 R8 outcome ", name}, res_status, exp_st);
        chk({"R6 results ", name}, results, exp_res);
        chk({"R4 R5 access count ", name}, lg_wr.size(), ex_wr.size());
        for (int i = 0; i < ex_wr.size() && i < lg_wr.size(); i++) begin
            chk({"R4 R6 access kind ", name}, lg_wr[i], ex_wr[i]);
            chk({"R4 R6 access offset ", name}, lg_off[i], ex_off[i]);
            if (ex_wr[i]) chk({"R4 write data ", name}, lg_dat[i], ex_dat[i]);
        end
        @(negedge clk);
        chk({"R11 strobe one cycle ", name}, res_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 strobe", res_valid, 0);
        chk("R1 write channels", {awvalid, wvalid, bready}, 0);
        chk("R1 read channels", {arvalid, rready}, 0);

        run_call("add", 32'd1, {32'd4, 32'd3, 32'd2, 32'd1}, 3, -1);             // R6
        run_call("echo", 32'd0, {32'hDEADBEEF, 32'h0BADF00D, 32'h12345678, 32'hA5A5A5A5}, 1, -1);
        run_call("add wrap", 32'd1, {32'h8000_0000, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF}, 7, -1);
        run_call("last poll", 32'd1, {32'd40, 32'd30, 32'd20, 32'd10}, 100, -1);   // R5 boundary
        run_call("timeout", 32'd1, {32'd5, 32'd6, 32'd7, 32'd8}, NEVER, -1);       // R7
        run_call("write err", 32'd1, {32'd9, 32'd9, 32'd9, 32'd9}, 3, 2);          // R8 BRESP
        run_call("read err", 32'd0, {32'd1, 32'd2, 32'd3, 32'd4}, 5, 7);           // R8 RRESP

        // R3: second start pulse mid-call is ignored
        fork
            run_call("busy go", 32'd1, {32'd100, 32'd200, 32'd300, 32'd400}, 6, -1);
            begin
                repeat (20) @(negedge clk);
                method = 32'd0; args = '1; go = 1;
                @(negedge clk);
                go = 0;
            end
        join
        begin
            int n;
            n = lg_wr.size();
            repeat (30) @(negedge clk);
            chk("R3 no extra call busy", busy, 0);
            chk("R3 no extra accesses", lg_wr.size(), n);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule